// File: doc/BRIEF.md
# Header-Tagged Serial Memory Boot Loader

This block is the first-stage loader that pulls a boot image out of a serial memory over a single-bit SPI link in mode 0. It issues the plain read command (0x03) and then 32 zero address bits. That is enough for a memory that decodes 16, 24 or 32 address bits. A narrower part ignores the extra zero bits and starts returning data early. The loader does not need to know which kind of part is fitted.

Because the first valid data byte lands at a different place in the stream depending on the part, the loader hunts through the returned bytes for a 4-byte key. The image is framed as key, length, payload and check. A few padding bytes in front of the key cover every start offset. Two keys are recognised: one marks a direct image and one marks a second-stage loader, and a flag reports which key was found.

After the key, the block reads a little-endian length, streams that many payload bytes to the consumer on a one-cycle valid strobe, and compares a trailing 32-bit sum. It ends with done or fail held until the next start. If fail is raised, the consumer must throw away any payload it has already taken.

Top module: `spi_boot_loader`

## Requirements
- R1: The link runs in SPI mode 0 with sck idle low. The first 40 bits shifted out on mosi are 0x03 followed by 32 zero bits, most significant bit first. mosi does not change while sck is high.
- R2: The first rising edge of sck comes CLK_DIV + CLK_DIV/2 system clocks after cs_n falls, and sck runs at the system clock divided by CLK_DIV.
- R3: The same image, with two padding bytes in front of the key, loads identically from a part that starts returning address-0 data on bit 24, bit 32 or bit 40 of the transaction.
- R4: Every byte received after the five command/address bytes is discarded until the last four bytes, first-received byte in the most significant position, equal KEY_DIRECT or KEY_STAGED. two_stage is 1 exactly when KEY_STAGED matched.
- R5: A key whose final byte is the SCAN_LIMIT-th byte after the address phase is accepted. If no key has been completed by that byte, the load fails. An undriven line (all 0xFF) therefore fails.
- R6: The four bytes after the key form the payload length, little-endian. Exactly that many payload bytes follow on data_out, each with one data_valid cycle, in memory order.
- R7: A length of zero or greater than MAX_LEN raises fail with no data_valid pulse.
- R8: The four bytes after the payload are compared, little-endian, with the sum modulo 2^32 of the payload bytes. A match raises done and a mismatch raises fail; done and fail are never high together.
- R9: cs_n returns high at the end of the final byte of the transaction. sck is low whenever cs_n is high.
- R10: start is ignored while a load is in progress. done, fail and two_stage hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted when no load is running) |
| miso | input | 1 | Serial data from the memory, pulled up when undriven |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low memory select |
| mosi | output | 1 | Serial data to the memory |
| data_out | output | 8 | Payload byte |
| data_valid | output | 1 | One-cycle strobe for data_out |
| done | output | 1 | Load finished with a good check |
| fail | output | 1 | Load failed (no key, bad length or bad check) |
| two_stage | output | 1 | The staged-loader key was matched |

## Verification
The bench sweeps all three start offsets against both keys and several payload lengths. A loader that assumed a fixed offset would lose or misread bytes on two of the three parts. It probes the scan window at its last accepted byte and one byte beyond. An off-by-one counter would either reject a legal image or accept a late one. Zero, over-limit and high-byte lengths are tried, and check values with a single low or high bit flipped. Wrong byte order or a truncated compare would let a corrupt image report done. A second start fired mid-load must not restart the transaction.

// File: rtl/spiboot_pkg.sv
package spiboot_pkg;

    localparam logic [7:0] READ_CMD   = 8'h03;
    localparam int         ADDR_BYTES = 4;
    localparam int         FIELD_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ADDR,
        ST_HUNT,
        ST_LEN,
        ST_DATA,
        ST_SUM,
        ST_END
    } boot_state_e;

    typedef struct packed {
        logic done;
        logic fail;
        logic two_stage;
    } boot_status_t;

    // Little-endian field assembly: the newest byte enters at the top.
    function automatic logic [31:0] le_push(input logic [31:0] acc, input logic [7:0] b);
        return {b, acc[31:8]};
    endfunction

    // Key window: the oldest byte drops out of the top.
    function automatic logic [31:0] win_push(input logic [31:0] win, input logic [7:0] b);
        return {win[23:0], b};
    endfunction

endpackage

// File: rtl/spiboot_shift_engine.sv
module spiboot_shift_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       keep,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int LO = CLK_DIV / 2;
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST_PH   = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] SAMPLE_PH = CW'(LO - 1);
    localparam logic [CW-1:0] HIGH_PH   = CW'(LO);

    logic [CW-1:0] phase;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          end_of_bit;

    assign end_of_bit = busy && (phase == LAST_PH);
    assign byte_done  = end_of_bit && (bit_idx == 3'd7);
    assign rx_byte    = rx_sh;
    assign sck        = busy && (phase >= HIGH_PH);
    assign mosi       = busy ? tx_sh[7] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            phase   <= '0;
            bit_idx <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy    <= 1'b1;
                phase   <= '0;
                bit_idx <= '0;
                tx_sh   <= tx_byte;
            end
        end else begin
            phase <= end_of_bit ? '0 : phase + 1'b1;
            if (phase == SAMPLE_PH) begin
                rx_sh <= {rx_sh[6:0], miso};
            end
            if (end_of_bit) begin
                if (bit_idx == 3'd7) begin
                    bit_idx <= '0;
                    tx_sh   <= tx_byte;
                    busy    <= keep;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    tx_sh   <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    // R1: the memory samples mosi on the rising edge, so it must not move while sck is high
    assert_mosi_stable_R1: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spiboot_key_match.sv
module spiboot_key_match #(
    parameter int                     NKEYS = 2,
    parameter logic [NKEYS*32-1:0]    KEYS  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift_en,
    input  logic [7:0]       byte_in,
    output logic [NKEYS-1:0] hit
);
    import spiboot_pkg::*;

    logic [31:0] win;
    logic [31:0] win_next;

    assign win_next = win_push(win, byte_in);

    // Window refills with 0xFF, a value no key may contain, so no stale match is possible.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            win <= '1;
        end else if (shift_en) begin
            win <= win_next;
        end
    end

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        assign hit[k] = shift_en && (win_next == KEYS[k*32 +: 32]);
    end

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader #(
    parameter int          CLK_DIV    = 4,
    parameter logic [31:0] KEY_DIRECT = 32'h4C44_3031,
    parameter logic [31:0] KEY_STAGED = 32'h4C44_3253,
    parameter int          SCAN_LIMIT = 64,
    parameter int          MAX_LEN    = 65536
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       miso,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    output logic [7:0] data_out,
    output logic       data_valid,
    output logic       done,
    output logic       fail,
    output logic       two_stage
);
    import spiboot_pkg::*;

    localparam int LW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BW = (SCAN_LIMIT > 7) ? $clog2(SCAN_LIMIT + 1) : 3;
    localparam int RW = $clog2(MAX_LEN + 1);
    localparam logic [LW-1:0] LEAD_LAST = LW'(CLK_DIV - 1);
    localparam logic [BW-1:0] SCAN_LAST = BW'(SCAN_LIMIT - 1);
    localparam logic [BW-1:0] ADDR_LAST = BW'(ADDR_BYTES);
    localparam logic [BW-1:0] FIELD_LAST = BW'(FIELD_BYTES - 1);

    boot_state_e  state;
    boot_status_t status;
    logic [LW-1:0] lead_cnt;
    logic [BW-1:0] bcnt;
    logic [31:0]   len_acc;
    logic [31:0]   sum_acc;
    logic [31:0]   rx_sum;
    logic [RW-1:0] remaining;

    logic       launch, keep, busy, byte_done;
    logic [7:0] tx_byte, rx_byte;
    logic [1:0] hit;
    logic       accept, shift_en;
    logic [31:0] len_full, sum_full;
    logic        len_bad, last_byte;

    assign accept   = start && (state == ST_IDLE || state == ST_END);
    assign launch   = (state == ST_LEAD) && (lead_cnt == LEAD_LAST);
    assign tx_byte  = (state == ST_LEAD) ? READ_CMD : 8'h00;
    assign shift_en = byte_done && (state == ST_HUNT);
    assign len_full = le_push(len_acc, rx_byte);
    assign sum_full = le_push(rx_sum, rx_byte);
    assign len_bad  = (len_full == 32'd0) || (len_full > 32'(MAX_LEN));

    always_comb begin
        unique case (state)
            ST_HUNT: last_byte = !(|hit) && (bcnt == SCAN_LAST);
            ST_LEN:  last_byte = (bcnt == FIELD_LAST) && len_bad;
            ST_SUM:  last_byte = (bcnt == FIELD_LAST);
            default: last_byte = 1'b0;
        endcase
    end
    assign keep = !last_byte;

    spiboot_shift_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .keep      (keep),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .busy      (busy),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    spiboot_key_match #(.NKEYS(2), .KEYS({KEY_STAGED, KEY_DIRECT})) u_match (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .shift_en (shift_en),
        .byte_in  (rx_byte),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            status     <= '0;
            cs_n       <= 1'b1;
            lead_cnt   <= '0;
            bcnt       <= '0;
            len_acc    <= '0;
            sum_acc    <= '0;
            rx_sum     <= '0;
            remaining  <= '0;
            data_out   <= '0;
            data_valid <= 1'b0;
        end else begin
            data_valid <= 1'b0;
            unique case (state)
                ST_IDLE, ST_END: begin
                    if (accept) begin
                        state    <= ST_LEAD;
                        status   <= '0;
                        cs_n     <= 1'b0;
                        lead_cnt <= '0;
                    end
                end
                ST_LEAD: begin
                    lead_cnt <= lead_cnt + 1'b1;
                    if (launch) begin
                        state <= ST_ADDR;
                        bcnt  <= '0;
                    end
                end
                ST_ADDR: begin
                    if (byte_done) begin
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == ADDR_LAST) begin
                            state <= ST_HUNT;
                            bcnt  <= '0;
                        end
                    end
                end
                ST_HUNT: begin
                    if (byte_done) begin
                        bcnt <= bcnt + 1'b1;
                        if (|hit) begin
                            state            <= ST_LEN;
                            status.two_stage <= hit[1];
                            bcnt             <= '0;
                        end else if (last_byte) begin
                            state       <= ST_END;
                            status.fail <= 1'b1;
                            cs_n        <= 1'b1;
                        end
                    end
                end
                ST_LEN: begin
                    if (byte_done) begin
                        bcnt    <= bcnt + 1'b1;
                        len_acc <= len_full;
                        if (bcnt == FIELD_LAST) begin
                            if (len_bad) begin
                                state       <= ST_END;
                                status.fail <= 1'b1;
                                cs_n        <= 1'b1;
                            end else begin
                                state     <= ST_DATA;
                                remaining <= RW'(len_full);
                                sum_acc   <= '0;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_done) begin
                        data_out   <= rx_byte;
                        data_valid <= 1'b1;
                        sum_acc    <= sum_acc + 32'(rx_byte);
                        remaining  <= remaining - 1'b1;
                        if (remaining == RW'(1)) begin
                            state <= ST_SUM;
                            bcnt  <= '0;
                        end
                    end
                end
                ST_SUM: begin
                    if (byte_done) begin
                        bcnt   <= bcnt + 1'b1;
                        rx_sum <= sum_full;
                        if (last_byte) begin
                            state <= ST_END;
                            cs_n  <= 1'b1;
                            if (sum_full == sum_acc) status.done <= 1'b1;
                            else                     status.fail <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done      = status.done;
    assign fail      = status.fail;
    assign two_stage = status.two_stage;

    // R9: the clock never toggles with the memory deselected
    assert_sck_idle_R9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R9: a result only appears once the memory has been released
    assert_cs_released_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) || $rose(fail)) |-> (cs_n && !busy));

    // R8: one outcome per load
    assert_result_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));

    // R6: payload strobes only occur inside an open transaction
    assert_valid_framed_R6: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (!cs_n && !done && !fail));

    // R10: results persist until a new start
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    assert_fail_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

endmodule

// File: tb/spi_boot_loader_bench.sv
module spi_boot_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int LIMIT = 64;
    localparam int MAXL  = 48;
    localparam logic [31:0] KD = 32'h4C44_3031;
    localparam logic [31:0] KS = 32'h4C44_3253;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic miso = 1'b1;
    logic sck, cs_n, mosi, data_valid, done, fail, two_stage;
    logic [7:0] data_out;

    spi_boot_loader #(
        .CLK_DIV(DIV), .KEY_DIRECT(KD), .KEY_STAGED(KS),
        .SCAN_LIMIT(LIMIT), .MAX_LEN(MAXL)
    ) u_spi_boot_loader (
        .clk(clk), .rst(rst), .start(start), .miso(miso), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .data_out(data_out), .data_valid(data_valid),
        .done(done), .fail(fail), .two_stage(two_stage)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Memory model
    logic [7:0] mem [0:255];
    logic [7:0] exp_pl [0:255];
    int mem_len = 0;
    int aw = 32;
    int edges = 0;
    logic [39:0] shreg = '0;
    logic [39:0] cmd_seen = '1;

    function automatic logic model_bit(input int b);
        int k;
        int idx;
        if (b < 8 + aw) return 1'b1;
        k = b - 8 - aw;
        idx = k / 8;
        if (idx >= mem_len || idx > 255) return 1'b1;
        return mem[idx][7 - (k % 8)];
    endfunction

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            edges <= 0;
            shreg <= '0;
        end else begin
            shreg <= {shreg[38:0], mosi};
            if (edges == 39) cmd_seen <= {shreg[38:0], mosi};
            edges <= edges + 1;
        end
    end

    always @(negedge sck or posedge cs_n) begin
        miso <= cs_n ? 1'b1 : model_bit(edges);
    end

    // Payload capture
    int got = 0;
    int mism = 0;
    int base = 0;
    always @(negedge clk) begin
        if (data_valid) begin
            if (data_out !== exp_pl[(got - base) % 256]) mism <= mism + 1;
            got <= got + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic build_image(input int pad, input logic [31:0] key, input logic [31:0] lenf,
                               input int plen, input logic [31:0] flip, input int seed);
        int idx;
        logic [31:0] s;
        idx = 0;
        s = '0;
        for (int i = 0; i < pad; i++) begin
            mem[idx] = (i % 2 == 0) ? 8'hFF : 8'h00;
            idx++;
        end
        for (int j = 0; j < 4; j++) begin
            mem[idx] = key[31 - 8*j -: 8];
            idx++;
        end
        for (int j = 0; j < 4; j++) begin
            mem[idx] = lenf[8*j +: 8];
            idx++;
        end
        for (int i = 0; i < plen; i++) begin
            exp_pl[i] = 8'((i * 37 + seed * 11 + 5) & 255);
            mem[idx] = exp_pl[i];
            s = s + 32'(exp_pl[i]);
            idx++;
        end
        s = s ^ flip;
        for (int j = 0; j < 4; j++) begin
            mem[idx] = s[8*j +: 8];
            idx++;
        end
        mem_len = idx;
    endtask

    int r_cnt, r_mism, t_cs, t_sck;
    bit r_done, r_fail, r_stage, r_cs, r_sck, r_ok;

    task automatic run_load(input int awid, input bit inject);
        int i;
        bit finished;
        aw = awid;
        base = got;
        r_mism = mism;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        t_cs = -1;
        t_sck = -1;
        finished = 0;
        i = 0;
        while (!finished && i < 40000) begin
            if (!cs_n && t_cs < 0) t_cs = cyc;
            if (sck && t_sck < 0) t_sck = cyc;
            if (done || fail) finished = 1;
            else begin
                start = (inject && i == 300);
                @(negedge clk);
                i++;
            end
        end
        start = 1'b0;
        r_ok = finished;
        repeat (2) @(negedge clk);
        r_done = done;
        r_fail = fail;
        r_stage = two_stage;
        r_cnt = got - base;
        r_mism = mism - r_mism;
        r_cs = cs_n;
        r_sck = sck;
        chk(r_ok, "R9", "load finished", 0, 1);
        chk(r_cs && !r_sck, "R9", "cs_n high and sck low after load", {r_cs, r_sck}, 2);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int lens [4];
        int awl [3];
        logic [31:0] key;
        lens = '{1, 3, 17, 48};
        awl = '{16, 24, 32};

        repeat (5) @(negedge clk);
        chk(cs_n === 1'b1 && sck === 1'b0, "R9", "reset idle pins", {cs_n, sck}, 2);
        chk(done === 1'b0 && fail === 1'b0 && data_valid === 1'b0, "R10", "reset flags",
            {done, fail, data_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R3 R4 R6 R8: sweep address width x key x length
        for (int a = 0; a < 3; a++) begin
            for (int k = 0; k < 2; k++) begin
                for (int l = 0; l < 4; l++) begin
                    key = (k == 1) ? KS : KD;
                    build_image(2 + (lens[l] % 3), key, 32'(lens[l]), lens[l], 32'd0, a * 8 + k * 4 + l);
                    run_load(awl[a], 1'b0);
                    chk(r_done && !r_fail, "R3", "done for width sweep", {r_done, r_fail}, 2);
                    chk(r_stage == k[0], "R4", "two_stage flag", r_stage, k);
                    chk(r_cnt == lens[l], "R6", "payload byte count", r_cnt, lens[l]);
                    chk(r_mism == 0, "R6", "payload mismatches", r_mism, 0);
                    if (a == 0 && k == 0 && l == 0) begin
                        chk(cmd_seen == {8'h03, 32'h0}, "R1", "read command and address bits",
                            cmd_seen, {8'h03, 32'h0});
                        chk(t_sck - t_cs == DIV + DIV / 2, "R2", "select to first sck rise",
                            t_sck - t_cs, DIV + DIV / 2);
                    end
                end
            end
        end

        // R5: undriven line never shows a key
        mem_len = 0;
        run_load(24, 1'b0);
        chk(r_fail && !r_done, "R5", "fail on idle line", {r_done, r_fail}, 1);
        chk(r_cnt == 0, "R5", "no payload on idle line", r_cnt, 0);

        // R5: key ending on the last scanned byte is accepted, one later is not
        build_image(LIMIT - 4, KS, 32'd5, 5, 32'd0, 3);
        run_load(32, 1'b0);
        chk(r_done && r_cnt == 5, "R5", "key at scan limit", {r_done, 8'(r_cnt)}, {1'b1, 8'd5});
        build_image(LIMIT - 3, KS, 32'd5, 5, 32'd0, 3);
        run_load(32, 1'b0);
        chk(r_fail && r_cnt == 0, "R5", "key past scan limit", {r_fail, 8'(r_cnt)}, {1'b1, 8'd0});

        // R7: bad lengths
        build_image(2, KD, 32'd0, 0, 32'd0, 1);
        run_load(16, 1'b0);
        chk(r_fail && r_cnt == 0, "R7", "zero length", {r_fail, 8'(r_cnt)}, {1'b1, 8'd0});
        build_image(2, KD, 32'(MAXL + 1), MAXL + 1, 32'd0, 2);
        run_load(24, 1'b0);
        chk(r_fail && r_cnt == 0, "R7", "length above max", {r_fail, 8'(r_cnt)}, {1'b1, 8'd0});
        build_image(2, KD, 32'h0100_0005, 5, 32'd0, 2);
        run_load(32, 1'b0);
        chk(r_fail && r_cnt == 0, "R7", "length high byte set", {r_fail, 8'(r_cnt)}, {1'b1, 8'd0});

        // R8: corrupted check field in low and high byte
        build_image(2, KD, 32'd9, 9, 32'h0000_0001, 4);
        run_load(24, 1'b0);
        chk(r_fail && !r_done, "R8", "low check byte flipped", {r_done, r_fail}, 1);
        chk(r_cnt == 9, "R8", "payload streamed before check", r_cnt, 9);
        build_image(2, KS, 32'd40, 40, 32'h0100_0000, 6);
        run_load(16, 1'b0);
        chk(r_fail && !r_done, "R8", "high check byte flipped", {r_done, r_fail}, 1);

        // R10: mid-load start ignored, result held afterwards
        build_image(3, KS, 32'd20, 20, 32'd0, 7);
        run_load(24, 1'b1);
        chk(r_done && r_cnt == 20 && r_mism == 0, "R10", "start during load ignored",
            {r_done, 8'(r_cnt)}, {1'b1, 8'd20});
        repeat (50) @(negedge clk);
        chk(done && !fail && two_stage, "R10", "result held while idle",
            {done, fail, two_stage}, 3'b101);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule